// File: doc/BRIEF.md
# Dimming Lamp Ballast Mode Controller

This block sequences a dimming fluorescent ballast through its four operating modes: supply lockout, preheat/ignition, dimming and fault. It works on digitized measurements. An 8-bit code gives the supply level. A second 8-bit code gives the voltage on the low-side gate pin. A third 8-bit code gives the frequency-sweep ramp level. Two single-bit flags report that the lamp has ignited and that the crest-factor detector has tripped. All threshold comparisons use separate rising and falling constants. Hysteresis therefore lives in registered flags that the mode logic owns, and not in the analog front end.

While the controller is in lockout or fault, the half-bridge is stopped and the low-side driver floats. The ramp node is held at zero. The floating low-side pin then serves as a lamp-presence sense: a pulled-up pin means the lamp is out, and a pulled-down pin means a filament is present. That sense both holds off start-up and clears a latched fault. In preheat the sweep source starts in quick-start and falls back to the slow current once the ramp passes its knee. The controller enters dimming on ignition, or fault if the ramp runs out first. Dimming enables the current-regulation loop and both protections.

Every output is registered. An input change reaches the outputs two clock edges later: one edge for sensing, one for the mode and drive registers.

Top module: `lamp_ballast_ctrl`

## Requirements
- R1: After a synchronous reset the mode reads 00 (lockout) with `hb_en`=0, `lo_hiz`=1, `vco_rst`=1 and `sweep_qs`, `dim_loop_en`, `zvs_prot_en`, `crest_prot_en` all 0.
- R2: From lockout the mode becomes 01 (preheat) only when the supply flag is set (`vcc_code` > 125) and the lamp flag shows inserted (`lo_code` < 85 seen while sensing). A supply code of exactly 125 does not start it.
- R3: The mode drives the outputs as follows. Modes 00 and 11 give `hb_en`=0, `lo_hiz`=1 and `vco_rst`=1. Modes 01 and 10 give `hb_en`=1, `lo_hiz`=0 and `vco_rst`=0. The dimming loop and protection enables are 1 only in mode 10.
- R4: The supply flag clears only when `vcc_code` < 105. Codes from 105 to 125 keep its previous value. A cleared flag sends preheat, dimming or fault to lockout.
- R5: The lamp flag shows removed when `lo_code` > 87 and inserted when `lo_code` < 85. Codes 85 to 87 keep its previous value. A removed lamp keeps the controller in lockout even when the supply flag is set.
- R6: `lo_code` is sensed only in lockout and fault. In preheat and dimming it has no effect on the mode.
- R7: In preheat, `sweep_qs` is 1 until `ramp_code` has exceeded 42. It then stays 0 for the rest of that preheat, even if the ramp code falls. Each new entry into preheat starts again in quick-start. Outside preheat it is 0.
- R8: In preheat, `ramp_code` > 200 without ignition gives mode 11 (fault). A code of 200 does not. Ignition seen in the same cycle takes priority and gives mode 10.
- R9: `ignited` in preheat gives mode 10. In dimming, the ramp code and a falling `ignited` have no effect.
- R10: `crest_flt` in dimming gives mode 11. In preheat it has no effect.
- R11: Fault is held regardless of ramp, ignition or crest inputs. It is left for lockout only by lamp removal (`lo_code` > 87) or by a supply drop (`vcc_code` < 105). After a supply cycle with the lamp present, the controller restarts in preheat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_code | input | 8 | Supply level code, 0.1 V per LSB |
| lo_code | input | 8 | Low-side pin level code, 0.1 V per LSB |
| ramp_code | input | 8 | Sweep ramp level code, 20 mV per LSB |
| ignited | input | 1 | Lamp ignition detected |
| crest_flt | input | 1 | Crest factor above limit |
| mode | output | 2 | 00 lockout, 01 preheat, 10 dimming, 11 fault |
| hb_en | output | 1 | Half-bridge oscillation enable |
| lo_hiz | output | 1 | Low-side driver tri-state (sense) control |
| sweep_qs | output | 1 | 1 selects quick-start charge, 0 the slow sweep |
| vco_rst | output | 1 | Hold ramp node at zero |
| dim_loop_en | output | 1 | Lamp-current regulation loop enable |
| zvs_prot_en | output | 1 | Hard-switching protection enable |
| crest_prot_en | output | 1 | Crest-factor protection enable |

## Verification
Each input code is walked across its hysteresis band one step at a time: at the threshold, inside the band and just past it. This separates a correct hysteretic flag from a plain comparator and from an off-by-one threshold. The low-side pin code is moved while the bridge runs and again while the controller is stopped, which shows that presence sensing is gated by mode. Ramp, ignition and crest inputs are raised alone and together in preheat, dimming and fault. These cases expose the wrong priority between fault and ignition, and a fault latch that releases on the wrong stimulus. The ramp is also lowered after the quick-start knee and preheat is re-entered, which tells a sticky, per-entry quick-start select apart from a plain level compare.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    M_LOCK = 2'b00,
    M_PRE  = 2'b01,
    M_DIM  = 2'b10,
    M_FLT  = 2'b11
  } mode_e;

  typedef struct packed {
    logic supply_ok;
    logic lamp_in;
    logic ramp_knee;
    logic ramp_over;
    logic ignite;
    logic crest;
  } sense_t;

  typedef struct packed {
    logic hb_en;
    logic lo_hiz;
    logic sweep_qs;
    logic vco_rst;
    logic dim_loop_en;
    logic zvs_en;
    logic crest_en;
  } drive_t;

  localparam drive_t DRV_IDLE = '{hb_en: 1'b0, lo_hiz: 1'b1, sweep_qs: 1'b0,
                                  vco_rst: 1'b1, dim_loop_en: 1'b0,
                                  zvs_en: 1'b0, crest_en: 1'b0};
endpackage

// File: rtl/lb_hyst.sv
module lb_hyst #(
  parameter int W       = 8,
  parameter int SET_LVL = 125,
  parameter int CLR_LVL = 105,
  parameter bit SET_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] code,
  output logic         flag
);
  localparam logic [W-1:0] SET_C = SET_LVL[W-1:0];
  localparam logic [W-1:0] CLR_C = CLR_LVL[W-1:0];

  logic set_hit, clr_hit;

  generate
    if (SET_LOW) begin : g_low_sets
      assign set_hit = code < SET_C;
      assign clr_hit = code > CLR_C;
    end else begin : g_high_sets
      assign set_hit = code > SET_C;
      assign clr_hit = code < CLR_C;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                     flag <= 1'b0;
    else if (upd && set_hit)     flag <= 1'b1;
    else if (upd && clr_hit)     flag <= 1'b0;
  end
endmodule

// File: rtl/lb_sense.sv
module lb_sense
  import lb_pkg::*;
#(
  parameter int W         = 8,
  parameter int VCC_ON    = 125,
  parameter int VCC_OFF   = 105,
  parameter int LO_INS    = 85,
  parameter int LO_REM    = 87,
  parameter int RAMP_KNEE = 42,
  parameter int RAMP_OVER = 200
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lo_sense_en,
  input  logic [W-1:0] vcc_code,
  input  logic [W-1:0] lo_code,
  input  logic [W-1:0] ramp_code,
  input  logic         ignited,
  input  logic         crest_flt,
  output sense_t       sns
);
  localparam logic [W-1:0] KNEE_C = RAMP_KNEE[W-1:0];
  localparam logic [W-1:0] OVER_C = RAMP_OVER[W-1:0];

  logic supply_ok, lamp_in;

  lb_hyst #(.W(W), .SET_LVL(VCC_ON), .CLR_LVL(VCC_OFF), .SET_LOW(1'b0)) u_supply (
    .clk (clk), .rst (rst), .upd (1'b1), .code (vcc_code), .flag (supply_ok)
  );

  lb_hyst #(.W(W), .SET_LVL(LO_INS), .CLR_LVL(LO_REM), .SET_LOW(1'b1)) u_lamp (
    .clk (clk), .rst (rst), .upd (lo_sense_en), .code (lo_code), .flag (lamp_in)
  );

  logic knee_q, over_q, ign_q, crest_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      knee_q  <= 1'b0;
      over_q  <= 1'b0;
      ign_q   <= 1'b0;
      crest_q <= 1'b0;
    end else begin
      knee_q  <= ramp_code > KNEE_C;
      over_q  <= ramp_code > OVER_C;
      ign_q   <= ignited;
      crest_q <= crest_flt;
    end
  end

  always_comb begin
    sns.supply_ok = supply_ok;
    sns.lamp_in   = lamp_in;
    sns.ramp_knee = knee_q;
    sns.ramp_over = over_q;
    sns.ignite    = ign_q;
    sns.crest     = crest_q;
  end
endmodule

// File: rtl/lb_mode_fsm.sv
module lb_mode_fsm
  import lb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  sense_t sns,
  output mode_e  mode_q,
  output mode_e  mode_d,
  output logic   lo_sense_en
);
  always_comb begin
    mode_d = mode_q;
    if (!sns.supply_ok) begin
      mode_d = M_LOCK;
    end else begin
      unique case (mode_q)
        M_LOCK: if (sns.lamp_in)        mode_d = M_PRE;
        M_PRE: begin
          if (sns.ignite)               mode_d = M_DIM;
          else if (sns.ramp_over)       mode_d = M_FLT;
        end
        M_DIM:  if (sns.crest)          mode_d = M_FLT;
        M_FLT:  if (!sns.lamp_in)       mode_d = M_LOCK;
        default:                        mode_d = M_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_LOCK;
    else     mode_q <= mode_d;
  end

  assign lo_sense_en = (mode_q == M_LOCK) || (mode_q == M_FLT);
endmodule

// File: rtl/lb_drive.sv
module lb_drive
  import lb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  mode_e  mode_d,
  input  logic   ramp_knee,
  output drive_t drv
);
  logic   knee_seen_q, knee_seen_d;
  drive_t drv_d;

  always_comb begin
    knee_seen_d       = (mode_d == M_PRE) && (knee_seen_q || ramp_knee);
    drv_d             = DRV_IDLE;
    unique case (mode_d)
      M_PRE: begin
        drv_d.hb_en    = 1'b1;
        drv_d.lo_hiz   = 1'b0;
        drv_d.vco_rst  = 1'b0;
        drv_d.sweep_qs = !knee_seen_d;
      end
      M_DIM: begin
        drv_d.hb_en       = 1'b1;
        drv_d.lo_hiz      = 1'b0;
        drv_d.vco_rst     = 1'b0;
        drv_d.dim_loop_en = 1'b1;
        drv_d.zvs_en      = 1'b1;
        drv_d.crest_en    = 1'b1;
      end
      default: drv_d = DRV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      knee_seen_q <= 1'b0;
      drv         <= DRV_IDLE;
    end else begin
      knee_seen_q <= knee_seen_d;
      drv         <= drv_d;
    end
  end
endmodule

// File: rtl/lamp_ballast_ctrl.sv
module lamp_ballast_ctrl
  import lb_pkg::*;
#(
  parameter int CODE_W       = 8,
  parameter int SUPPLY_LSB_MV = 100,
  parameter int RAMP_LSB_MV   = 20,
  parameter int VCC_ON_MV     = 12500,
  parameter int VCC_OFF_MV    = 10500,
  parameter int LO_INS_MV     = 8500,
  parameter int LO_REM_MV     = 8750,
  parameter int KNEE_MV       = 850,
  parameter int OVER_MV       = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] vcc_code,
  input  logic [CODE_W-1:0] lo_code,
  input  logic [CODE_W-1:0] ramp_code,
  input  logic              ignited,
  input  logic              crest_flt,
  output logic [1:0]        mode,
  output logic              hb_en,
  output logic              lo_hiz,
  output logic              sweep_qs,
  output logic              vco_rst,
  output logic              dim_loop_en,
  output logic              zvs_prot_en,
  output logic              crest_prot_en
);
  localparam int VCC_ON_C  = VCC_ON_MV  / SUPPLY_LSB_MV;
  localparam int VCC_OFF_C = VCC_OFF_MV / SUPPLY_LSB_MV;
  localparam int LO_INS_C  = LO_INS_MV  / SUPPLY_LSB_MV;
  localparam int LO_REM_C  = LO_REM_MV  / SUPPLY_LSB_MV;
  localparam int KNEE_C    = KNEE_MV    / RAMP_LSB_MV;
  localparam int OVER_C    = OVER_MV    / RAMP_LSB_MV;

  sense_t sns;
  mode_e  mode_q, mode_d;
  logic   lo_sense_en;
  drive_t drv;

  lb_sense #(
    .W(CODE_W), .VCC_ON(VCC_ON_C), .VCC_OFF(VCC_OFF_C),
    .LO_INS(LO_INS_C), .LO_REM(LO_REM_C),
    .RAMP_KNEE(KNEE_C), .RAMP_OVER(OVER_C)
  ) u_sense (
    .clk (clk), .rst (rst), .lo_sense_en (lo_sense_en),
    .vcc_code (vcc_code), .lo_code (lo_code), .ramp_code (ramp_code),
    .ignited (ignited), .crest_flt (crest_flt), .sns (sns)
  );

  lb_mode_fsm u_fsm (
    .clk (clk), .rst (rst), .sns (sns),
    .mode_q (mode_q), .mode_d (mode_d), .lo_sense_en (lo_sense_en)
  );

  lb_drive u_drive (
    .clk (clk), .rst (rst), .mode_d (mode_d),
    .ramp_knee (sns.ramp_knee), .drv (drv)
  );

  assign mode          = mode_q;
  assign hb_en         = drv.hb_en;
  assign lo_hiz        = drv.lo_hiz;
  assign sweep_qs      = drv.sweep_qs;
  assign vco_rst       = drv.vco_rst;
  assign dim_loop_en   = drv.dim_loop_en;
  assign zvs_prot_en   = drv.zvs_en;
  assign crest_prot_en = drv.crest_en;
endmodule

// File: rtl/lb_ctrl_chk.sv
module lb_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       hb_en,
  input logic       lo_hiz,
  input logic       sweep_qs,
  input logic       vco_rst,
  input logic       crest_prot_en
);
  a_r3_bridge_excludes_float: assert property (@(posedge clk) disable iff (rst)
    hb_en |-> (!lo_hiz && !vco_rst));

  a_r3_crest_only_when_running: assert property (@(posedge clk) disable iff (rst)
    crest_prot_en |-> hb_en);

  a_r2_lockout_exits_to_preheat: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (mode == 2'b00 || mode == 2'b01));

  a_r11_fault_exits_to_lockout: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (mode == 2'b11 || mode == 2'b00));

  a_r9_dim_never_back_to_preheat: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (mode != 2'b01));

  a_r7_slow_sweep_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !sweep_qs) |=> !(mode == 2'b01 && sweep_qs));
endmodule

bind lamp_ballast_ctrl lb_ctrl_chk u_chk (
  .clk (clk), .rst (rst), .mode (mode), .hb_en (hb_en), .lo_hiz (lo_hiz),
  .sweep_qs (sweep_qs), .vco_rst (vco_rst), .crest_prot_en (crest_prot_en)
);

// File: tb/tb_lamp_ballast_ctrl.sv
`timescale 1ns/1ps
module tb_lamp_ballast_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] vcc_code = '0, lo_code = '0, ramp_code = '0;
  logic       ignited = 1'b0, crest_flt = 1'b0;
  logic [1:0] mode;
  logic hb_en, lo_hiz, sweep_qs, vco_rst, dim_loop_en, zvs_prot_en, crest_prot_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lamp_ballast_ctrl dut (
    .clk (clk), .rst (rst), .vcc_code (vcc_code), .lo_code (lo_code),
    .ramp_code (ramp_code), .ignited (ignited), .crest_flt (crest_flt),
    .mode (mode), .hb_en (hb_en), .lo_hiz (lo_hiz), .sweep_qs (sweep_qs),
    .vco_rst (vco_rst), .dim_loop_en (dim_loop_en), .zvs_prot_en (zvs_prot_en),
    .crest_prot_en (crest_prot_en)
  );

  typedef struct {
    int         due;
    logic [1:0] m;
    logic       qs;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // Expected output vector from the mode table of R3 plus the R7 sweep select
  function automatic logic [8:0] expect_vec(input logic [1:0] m, input logic qs);
    logic run, dim;
    run = (m == 2'b01) || (m == 2'b10);
    dim = (m == 2'b10);
    return {m, run, !run, qs, !run, dim, dim, dim};
  endfunction

  task automatic compare(input logic [1:0] m, input logic qs, input string tag);
    logic [8:0] act, exp_v;
    act   = {mode, hb_en, lo_hiz, sweep_qs, vco_rst, dim_loop_en, zvs_prot_en, crest_prot_en};
    exp_v = expect_vec(m, qs);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp_v);
    end
  endtask

  // Monitor: pops scoreboard entries in the cycle they fall due
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      compare(sb[0].m, sb[0].qs, sb[0].tag);
      void'(sb.pop_front());
    end
  end

  // Driver: inputs change at a falling edge; result is two rising edges later
  task automatic go(input int v, input int l, input int r, input logic ig, input logic cf,
                    input logic [1:0] em, input logic eq, input string tag);
    exp_t e;
    @(negedge clk);
    vcc_code  = v[7:0];
    lo_code   = l[7:0];
    ramp_code = r[7:0];
    ignited   = ig;
    crest_flt = cf;
    e.due = cyc + 2;
    e.m   = em;
    e.qs  = eq;
    e.tag = tag;
    sb.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(2'b00, 1'b0, "R1 reset state");
    rst = 1'b0;
    //  vcc  lo   ramp ig cf  mode  qs
    go(125, 100,   0, 0, 0, 2'b00, 0, "R5 lamp removed holds lockout");
    go(125,  86,   0, 0, 0, 2'b00, 0, "R5 level inside lamp band");
    go(125,  84,   0, 0, 0, 2'b00, 0, "R2 supply at 125 does not start");
    go(126,  84,   0, 0, 0, 2'b01, 1, "R2 start preheat, R7 quick-start");
    go(126,  84,  42, 0, 0, 2'b01, 1, "R7 ramp at knee keeps quick-start");
    go(126,  84,  43, 0, 0, 2'b01, 0, "R7 ramp past knee selects slow sweep");
    go(126,  84,  10, 0, 0, 2'b01, 0, "R7 slow sweep sticky");
    go(126, 200,  10, 0, 0, 2'b01, 0, "R6 lo level ignored in preheat");
    go(105, 200,  10, 0, 0, 2'b01, 0, "R4 supply at 105 keeps running");
    go(104, 200,  10, 0, 0, 2'b00, 0, "R4 supply below 105 to lockout");
    go(150, 200,  10, 0, 0, 2'b00, 0, "R5 removal seen in lockout");
    go(150,  80,  10, 0, 0, 2'b01, 1, "R7 quick-start again on re-entry");
    go(150,  80, 200, 0, 0, 2'b01, 0, "R8 ramp at 200 no fault");
    go(150,  80, 201, 1, 0, 2'b10, 0, "R8 R9 ignition wins over ramp");
    go(150,  80, 255, 0, 0, 2'b10, 0, "R9 ramp and ignition drop ignored");
    go(150, 200, 255, 0, 0, 2'b10, 0, "R6 lo level ignored in dimming");
    go(110,  80, 255, 0, 0, 2'b10, 0, "R4 supply in band keeps dimming");
    go(110,  80, 255, 0, 1, 2'b11, 0, "R10 crest fault in dimming");
    go(110,  80,   0, 0, 0, 2'b11, 0, "R11 fault latched");
    go(110,  80,   0, 1, 0, 2'b11, 0, "R11 ignition ignored in fault");
    go(110,  86,   0, 0, 0, 2'b11, 0, "R11 lo level in band keeps fault");
    go(110,  88,   0, 0, 0, 2'b00, 0, "R11 lamp removal clears fault");
    go(110,  80,   0, 0, 0, 2'b01, 1, "R4 R2 restart with supply in band");
    go(110,  80,   0, 0, 1, 2'b01, 1, "R10 crest ignored in preheat");
    go(110,  80, 201, 0, 0, 2'b11, 0, "R8 ramp over 200 faults");
    go(100,  80, 201, 0, 0, 2'b00, 0, "R11 supply drop clears fault");
    go(150,  80,   0, 0, 0, 2'b01, 1, "R11 supply cycle restarts preheat");
    repeat (4) @(posedge clk);
    #1;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule